// File: doc/BRIEF.md
# DQS Strobe-Timing Eye Calibration Sequencer

This block is a hardware sequencer that finds a working strobe timing for a DDR memory controller after reset, with no software involved. It sweeps two settings. The outer loop steps a coarse write-strobe shift. The inner loop steps a fine delay-line value, and that value is applied to every byte lane at once. For each pair of settings the sequencer drops the controller's start bit, loads the new values and raises start again. It then waits for the delay-line lock flag, then for the initialization-complete flag, and then for a settle time. After that it writes a fixed 64-word pattern through a single-word memory port and reads every word back several times.

For each coarse shift, the sequencer scores runs of consecutive passing fine delays. It keeps the widest run seen. When two runs have the same width, the later one wins. Once the sweep ends, the controller is programmed with the coarse shift of the best run and with the midpoint of that run's fine window. A last restart cycle follows, and then the sequencer reports done. If a status flag fails to rise within the poll limit, the sequencer stops in an error state. In that state the configuration outputs still show the setting that was being tried.

Top module: `dqs_eye_cal`

## Requirements
- R1: After reset, settings are visited with the coarse shift as the outer loop, from SHIFT_LO up to SHIFT_HI, and the fine delay as the inner loop, from DLY_LO up to DLY_HI. Both loops count upward by one.
- R2: Each time start rises, cfg_out_shift equals cfg_wr_shift + OUT_OFS. All LANES fields of cfg_lane_dly carry the same value. Lane k occupies bits [k*DLY_W +: DLY_W].
- R3: For every setting, start is low while the values change and is then raised. The lock flag is awaited first and the init flag after it. Start goes low again after the test. The values on the configuration outputs do not change while start stays high.
- R4: Each flag wait polls for at most POLL_LIMIT cycles. If the flag does not rise in that time, cal_error is set and stays set, cal_done stays low, start stays high, and the configuration outputs keep the failing shift and delay.
- R5: Once init is seen, at least SETTLE_CYC cycles pass before the first pattern write.
- R6: The test writes PAT_WORDS words to addresses 0 upward. Bits [5:4] of the address pick a value pair: 0 gives 0000/FFFF, 1 gives AAAA/5555, 2 gives A5A5/5A5A, and 3 gives AA55/55AA. Each 16-bit unit is replicated across the word. The second value of the pair is used when address bit 1 XOR address bit 3 is 1. mem_we and mem_re are never high together.
- R7: Each word is read READS times. Read data is sampled one cycle after mem_re. The first mismatch fails the setting and ends its test at once.
- R8: A failing setting, or the first fine delay of a new coarse shift, restarts the pass run. A run whose length is at least the best so far replaces the best shift, window start, window end and length, so ties go to the later run.
- R9: After the sweep, the sequencer programs the best shift, with its output shift, and the fine delay floor((start+end)/2). It repeats start, lock, init and settle, then sets cal_done and holds it.
- R10: If no setting passes, no_window is set together with cal_done. The window outputs and the chosen shift and delay are then zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; calibration begins when it is released |
| lock_ok | input | 1 | Delay-line lock flag from the controller |
| init_ok | input | 1 | Initialization-complete flag from the controller |
| cfg_start | output | 1 | Controller start bit |
| cfg_wr_shift | output | SHIFT_W | Coarse write-strobe shift |
| cfg_out_shift | output | SHIFT_W | Output strobe shift (write shift + OUT_OFS) |
| cfg_lane_dly | output | LANES*DLY_W | Fine delay, one field per byte lane |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_addr | output | $clog2(PAT_WORDS) | Word address |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, valid one cycle after mem_re |
| cal_done | output | 1 | Calibration finished |
| cal_error | output | 1 | A flag wait timed out |
| no_window | output | 1 | No setting passed |
| win_lo | output | DLY_W | Start of the best fine window |
| win_hi | output | DLY_W | End of the best fine window |
| win_len | output | $clog2(DLY_HI+2) | Length of the best window |

## Verification
The bench narrows the sweep to four coarse shifts (64 to 67) and twelve fine delays. It sets READS to 2, POLL_LIMIT to 16 and SETTLE_CYC to 5, and keeps the full 64-word pattern. With these values a complete run, including row boundaries, ties between equal runs, odd and even midpoints, and the all-fail case, finishes within a few thousand cycles per scenario. Both flag-timeout paths can also be reached within a few cycles. Failing settings are injected by corrupting only the second read of word 0, which shows whether the read count and the early stop are both honoured.

// File: rtl/dqs_cal_pkg.sv
package dqs_cal_pkg;
  typedef enum logic [3:0] {
    ST_PROG, ST_ARM, ST_WLOCK, ST_WINIT, ST_SETTLE,
    ST_TEST, ST_SCORE, ST_DONE, ST_ERR
  } cal_state_e;

  typedef enum logic [2:0] {
    TS_IDLE, TS_WR, TS_RD_REQ, TS_RD_CHK, TS_FIN
  } tst_state_e;
endpackage

// File: rtl/dqs_pat_gen.sv
module dqs_pat_gen #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 6
) (
  input  logic [IDX_W-1:0]  idx,
  output logic [DATA_W-1:0] word
);
  localparam int UNITS = DATA_W / 16;
  logic [5:0]  i6;
  logic [15:0] va, vb, unit;

  always_comb begin
    i6 = 6'(idx);
    case (i6[5:4])
      2'd0:    begin va = 16'h0000; vb = 16'hFFFF; end
      2'd1:    begin va = 16'hAAAA; vb = 16'h5555; end
      2'd2:    begin va = 16'hA5A5; vb = 16'h5A5A; end
      default: begin va = 16'hAA55; vb = 16'h55AA; end
    endcase
    unit = (i6[1] ^ i6[3]) ? vb : va;
    word = {UNITS{unit}};
  end
endmodule

// File: rtl/dqs_pat_tester.sv
module dqs_pat_tester
  import dqs_cal_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int WORDS  = 64,
  parameter int READS  = 10
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     go,
  output logic                     t_done,
  output logic                     t_pass,
  output logic                     mem_we,
  output logic                     mem_re,
  output logic [$clog2(WORDS)-1:0] mem_addr,
  output logic [DATA_W-1:0]        mem_wdata,
  input  logic [DATA_W-1:0]        mem_rdata
);
  localparam int AW = $clog2(WORDS);
  localparam int RW = $clog2(READS + 1);
  localparam logic [AW-1:0] LAST = AW'(WORDS - 1);

  tst_state_e      st;
  logic [AW-1:0]   addr;
  logic [RW-1:0]   rcnt;
  logic [DATA_W-1:0] exp_word;

  dqs_pat_gen #(.DATA_W(DATA_W), .IDX_W(AW)) u_pat (.idx(addr), .word(exp_word));

  assign t_done = (st == TS_FIN);

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= TS_IDLE; addr <= '0; rcnt <= '0; t_pass <= 1'b0;
      mem_we <= 1'b0; mem_re <= 1'b0; mem_addr <= '0; mem_wdata <= '0;
    end else begin
      case (st)
        TS_IDLE: begin
          mem_we <= 1'b0; mem_re <= 1'b0;
          if (go) begin
            st <= TS_WR; addr <= '0; rcnt <= '0;
          end
        end
        TS_WR: begin
          mem_we    <= 1'b1;
          mem_addr  <= addr;
          mem_wdata <= exp_word;
          if (addr == LAST) begin
            st <= TS_RD_REQ; addr <= '0;
          end else begin
            addr <= addr + 1'b1;
          end
        end
        TS_RD_REQ: begin
          mem_we <= 1'b0; mem_re <= 1'b1; mem_addr <= addr;
          st <= TS_RD_CHK;
        end
        TS_RD_CHK: begin
          mem_re <= 1'b0;
          if (mem_rdata != exp_word) begin
            t_pass <= 1'b0; st <= TS_FIN;
          end else if (rcnt == RW'(READS - 1)) begin
            rcnt <= '0;
            if (addr == LAST) begin
              t_pass <= 1'b1; st <= TS_FIN;
            end else begin
              addr <= addr + 1'b1; st <= TS_RD_REQ;
            end
          end else begin
            rcnt <= rcnt + 1'b1; st <= TS_RD_REQ;
          end
        end
        default: begin
          mem_we <= 1'b0; mem_re <= 1'b0; st <= TS_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/dqs_win_track.sv
module dqs_win_track #(
  parameter int SHIFT_W = 7,
  parameter int DLY_W   = 7,
  parameter int LEN_W   = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               score,
  input  logic               pass,
  input  logic               row_start,
  input  logic [SHIFT_W-1:0] cur_shift,
  input  logic [DLY_W-1:0]   cur_dly,
  output logic [LEN_W-1:0]   best_len,
  output logic [SHIFT_W-1:0] best_shift,
  output logic [DLY_W-1:0]   best_lo,
  output logic [DLY_W-1:0]   best_hi
);
  logic [LEN_W-1:0] run, run_eff, run_nxt;
  logic [DLY_W-1:0] run_lo, lo_eff;

  always_comb begin
    run_eff = row_start ? '0 : run;
    run_nxt = run_eff + 1'b1;
    lo_eff  = (run_eff == '0) ? cur_dly : run_lo;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run <= '0; run_lo <= '0;
      best_len <= '0; best_shift <= '0; best_lo <= '0; best_hi <= '0;
    end else if (score) begin
      if (!pass) begin
        run <= '0;
      end else begin
        run    <= run_nxt;
        run_lo <= lo_eff;
        if (run_nxt >= best_len) begin
          best_len   <= run_nxt;
          best_shift <= cur_shift;
          best_lo    <= lo_eff;
          best_hi    <= cur_dly;
        end
      end
    end
  end
endmodule

// File: rtl/dqs_eye_cal.sv
module dqs_eye_cal
  import dqs_cal_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int LANES      = 9,
  parameter int SHIFT_W    = 7,
  parameter int DLY_W      = 7,
  parameter int SHIFT_LO   = 64,
  parameter int SHIFT_HI   = 95,
  parameter int OUT_OFS    = 32,
  parameter int DLY_LO     = 1,
  parameter int DLY_HI     = 63,
  parameter int PAT_WORDS  = 64,
  parameter int READS      = 10,
  parameter int POLL_LIMIT = 65535,
  parameter int CLK_MHZ    = 200,
  parameter int SETTLE_CYC = CLK_MHZ * 100
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         lock_ok,
  input  logic                         init_ok,
  output logic                         cfg_start,
  output logic [SHIFT_W-1:0]           cfg_wr_shift,
  output logic [SHIFT_W-1:0]           cfg_out_shift,
  output logic [LANES*DLY_W-1:0]       cfg_lane_dly,
  output logic                         mem_we,
  output logic                         mem_re,
  output logic [$clog2(PAT_WORDS)-1:0] mem_addr,
  output logic [DATA_W-1:0]            mem_wdata,
  input  logic [DATA_W-1:0]            mem_rdata,
  output logic                         cal_done,
  output logic                         cal_error,
  output logic                         no_window,
  output logic [DLY_W-1:0]             win_lo,
  output logic [DLY_W-1:0]             win_hi,
  output logic [$clog2(DLY_HI+2)-1:0]  win_len
);
  localparam int POLL_W = $clog2(POLL_LIMIT + 1);
  localparam int SET_W  = $clog2(SETTLE_CYC + 1);
  localparam int LEN_W  = $clog2(DLY_HI + 2);

  cal_state_e         st;
  logic [SHIFT_W-1:0] cur_shift, wr_q, out_q, best_shift, next_shift;
  logic [DLY_W-1:0]   cur_dly, dly_q, mid_dly, next_dly;
  logic               final_ph, tgo, t_done, t_pass;
  logic [POLL_W-1:0]  poll_cnt;
  logic [SET_W-1:0]   settle_cnt;
  logic [LEN_W-1:0]   best_len;
  logic [DLY_W-1:0]   best_lo, best_hi;

  dqs_pat_tester #(.DATA_W(DATA_W), .WORDS(PAT_WORDS), .READS(READS)) u_tst (
    .clk(clk), .rst(rst), .go(tgo), .t_done(t_done), .t_pass(t_pass),
    .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  dqs_win_track #(.SHIFT_W(SHIFT_W), .DLY_W(DLY_W), .LEN_W(LEN_W)) u_trk (
    .clk(clk), .rst(rst), .score(st == ST_SCORE), .pass(t_pass),
    .row_start(cur_dly == DLY_W'(DLY_LO)), .cur_shift(cur_shift), .cur_dly(cur_dly),
    .best_len(best_len), .best_shift(best_shift), .best_lo(best_lo), .best_hi(best_hi)
  );

  assign mid_dly    = DLY_W'(({1'b0, best_lo} + {1'b0, best_hi}) >> 1);
  assign next_shift = final_ph ? best_shift : cur_shift;
  assign next_dly   = final_ph ? mid_dly : cur_dly;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_PROG; cur_shift <= SHIFT_W'(SHIFT_LO); cur_dly <= DLY_W'(DLY_LO);
      final_ph <= 1'b0; poll_cnt <= '0; settle_cnt <= '0; tgo <= 1'b0;
      cfg_start <= 1'b0; wr_q <= '0; out_q <= '0; dly_q <= '0;
      cal_done <= 1'b0; cal_error <= 1'b0; no_window <= 1'b0;
    end else begin
      tgo <= 1'b0;
      case (st)
        ST_PROG: begin
          cfg_start <= 1'b0;
          wr_q  <= next_shift;
          out_q <= next_shift + SHIFT_W'(OUT_OFS);
          dly_q <= next_dly;
          st    <= ST_ARM;
        end
        ST_ARM: begin
          cfg_start <= 1'b1; poll_cnt <= '0; st <= ST_WLOCK;
        end
        ST_WLOCK: begin
          if (lock_ok) begin
            poll_cnt <= '0; st <= ST_WINIT;
          end else if (poll_cnt == POLL_W'(POLL_LIMIT - 1)) begin
            st <= ST_ERR;
          end else begin
            poll_cnt <= poll_cnt + 1'b1;
          end
        end
        ST_WINIT: begin
          if (init_ok) begin
            settle_cnt <= '0; st <= ST_SETTLE;
          end else if (poll_cnt == POLL_W'(POLL_LIMIT - 1)) begin
            st <= ST_ERR;
          end else begin
            poll_cnt <= poll_cnt + 1'b1;
          end
        end
        ST_SETTLE: begin
          if (settle_cnt == SET_W'(SETTLE_CYC - 1)) begin
            if (final_ph) st <= ST_DONE;
            else begin
              tgo <= 1'b1; st <= ST_TEST;
            end
          end else begin
            settle_cnt <= settle_cnt + 1'b1;
          end
        end
        ST_TEST: begin
          if (t_done) st <= ST_SCORE;
        end
        ST_SCORE: begin
          cfg_start <= 1'b0;
          st <= ST_PROG;
          if (cur_dly == DLY_W'(DLY_HI)) begin
            cur_dly <= DLY_W'(DLY_LO);
            if (cur_shift == SHIFT_W'(SHIFT_HI)) final_ph <= 1'b1;
            else cur_shift <= cur_shift + 1'b1;
          end else begin
            cur_dly <= cur_dly + 1'b1;
          end
        end
        ST_DONE: begin
          cal_done  <= 1'b1;
          no_window <= (best_len == '0);
        end
        default: begin
          cal_error <= 1'b1;
        end
      endcase
    end
  end

  assign cfg_wr_shift  = wr_q;
  assign cfg_out_shift = out_q;
  assign win_lo  = best_lo;
  assign win_hi  = best_hi;
  assign win_len = best_len;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign cfg_lane_dly[g*DLY_W +: DLY_W] = dly_q;
  end
endmodule

// File: rtl/dqs_eye_cal_chk.sv
module dqs_eye_cal_chk #(
  parameter int SHIFT_W = 7,
  parameter int DLY_W   = 7,
  parameter int LANES   = 9,
  parameter int LEN_W   = 7,
  parameter int OUT_OFS = 32
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   cfg_start,
  input logic [SHIFT_W-1:0]     cfg_wr_shift,
  input logic [SHIFT_W-1:0]     cfg_out_shift,
  input logic [LANES*DLY_W-1:0] cfg_lane_dly,
  input logic                   mem_we,
  input logic                   mem_re,
  input logic                   cal_done,
  input logic                   cal_error,
  input logic                   no_window,
  input logic [DLY_W-1:0]       win_lo,
  input logic [DLY_W-1:0]       win_hi,
  input logic [LEN_W-1:0]       win_len
);
  AST_OUT_SHIFT_OFS: assert property (@(posedge clk) disable iff (rst)
    $rose(cfg_start) |-> cfg_out_shift == cfg_wr_shift + SHIFT_W'(OUT_OFS)); // R2
  AST_CFG_HELD: assert property (@(posedge clk) disable iff (rst)
    (cfg_start && $past(cfg_start)) |-> ($stable(cfg_wr_shift) && $stable(cfg_lane_dly))); // R3
  AST_MEM_WHEN_STARTED: assert property (@(posedge clk) disable iff (rst)
    (mem_we || mem_re) |-> cfg_start); // R3
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    cal_error |=> (cal_error && !cal_done && cfg_start)); // R4
  AST_WE_RE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(mem_we && mem_re)); // R6
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
    cal_done |=> (cal_done && $stable(cfg_wr_shift) && $stable(cfg_lane_dly))); // R9
  AST_NOWIN_ZERO: assert property (@(posedge clk) disable iff (rst)
    no_window |-> (cal_done && win_len == '0 && win_lo == '0 && win_hi == '0)); // R10
endmodule

bind dqs_eye_cal dqs_eye_cal_chk #(
  .SHIFT_W(SHIFT_W), .DLY_W(DLY_W), .LANES(LANES), .LEN_W(LEN_W), .OUT_OFS(OUT_OFS)
) u_chk (
  .clk(clk), .rst(rst), .cfg_start(cfg_start), .cfg_wr_shift(cfg_wr_shift),
  .cfg_out_shift(cfg_out_shift), .cfg_lane_dly(cfg_lane_dly), .mem_we(mem_we),
  .mem_re(mem_re), .cal_done(cal_done), .cal_error(cal_error), .no_window(no_window),
  .win_lo(win_lo), .win_hi(win_hi), .win_len(win_len)
);

// File: tb/tb_dqs_eye_cal.sv
module tb_dqs_eye_cal;
  localparam int CLK_PERIOD = 10;
  localparam int NSH = 4, NDL = 12, SETTLE = 5;
  localparam int LANES = 9, DLY_W = 7, SHIFT_W = 7, AW = 6, LEN_W = 4;

  typedef struct packed {
    logic [47:0] mask;  // bit (shift-64)*12 + (dly-1) set = setting passes
    logic [6:0]  shift;
    logic [6:0]  lo;
    logic [6:0]  hi;
    logic [6:0]  mid;
    logic [3:0]  len;
    logic        nowin;
  } scen_t;

  localparam scen_t SCEN [5] = '{
    '{48'h000_F8E_07C_000, 7'd66, 7'd8, 7'd12, 7'd10, 4'd5,  1'b0},
    '{48'h000_000_000_000, 7'd0,  7'd0, 7'd0,  7'd0,  4'd0,  1'b1},
    '{48'h7FF_000_000_FFF, 7'd64, 7'd1, 7'd12, 7'd6,  4'd12, 1'b0},
    '{48'h000_000_001_800, 7'd65, 7'd1, 7'd1,  7'd1,  4'd1,  1'b0},
    '{48'h000_1F8_000_000, 7'd66, 7'd4, 7'd9,  7'd6,  4'd6,  1'b0}
  };

  logic clk = 1'b0, rst = 1'b1, lock_ok = 1'b0, init_ok = 1'b0;
  logic cfg_start, mem_we, mem_re, cal_done, cal_error, no_window;
  logic [SHIFT_W-1:0] cfg_wr_shift, cfg_out_shift;
  logic [LANES*DLY_W-1:0] cfg_lane_dly;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata = '0;
  logic [DLY_W-1:0] win_lo, win_hi;
  logic [LEN_W-1:0] win_len;

  always #(CLK_PERIOD/2) clk = ~clk;

  dqs_eye_cal #(
    .SHIFT_HI(67), .DLY_HI(12), .PAT_WORDS(64), .READS(2),
    .POLL_LIMIT(16), .SETTLE_CYC(SETTLE)
  ) dut (.*);

  int errors = 0, checks = 0;
  logic [47:0] cur_mask;
  int kill_lock_sh = -1, kill_lock_dl = -1, kill_init_sh = -1, kill_init_dl = -1;
  int st_cnt, pt_idx, order_err, wr_err, rd_err, settle_err, rd_pt, rd0;
  int cyc, init_cyc, seen_we;
  logic prev_start, prev_init;
  logic [31:0] mem [64];

  function automatic logic [31:0] pat(input int i);
    logic [15:0] a, b;
    case ((i >> 4) & 3)
      0: begin a = 16'h0000; b = 16'hFFFF; end
      1: begin a = 16'hAAAA; b = 16'h5555; end
      2: begin a = 16'hA5A5; b = 16'h5A5A; end
      default: begin a = 16'hAA55; b = 16'h55AA; end
    endcase
    return (((i >> 1) ^ (i >> 3)) & 1) ? {b, b} : {a, a};
  endfunction

  function automatic int lane(input int k);
    return int'(cfg_lane_dly[k*DLY_W +: DLY_W]);
  endfunction

  function automatic logic good_pt(input int sh, input int dl);
    return cur_mask[(sh - 64) * NDL + (dl - 1)];
  endfunction

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Controller and memory model, updated away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (rst) begin
      st_cnt = 0; lock_ok = 0; init_ok = 0; prev_start = 0; prev_init = 0;
    end else begin
      if (cfg_start && !prev_start) begin
        if (pt_idx < NSH*NDL &&
            (int'(cfg_wr_shift) != 64 + pt_idx / NDL || lane(0) != 1 + pt_idx % NDL))
          order_err++;
        pt_idx++; rd_pt = 0; rd0 = 0; seen_we = 0;
      end
      if (!cfg_start && prev_start) begin
        if (good_pt(int'(cfg_wr_shift), lane(0))) begin
          if (rd_pt != 128) rd_err++;
        end else if (rd_pt != 2) rd_err++;
      end
      prev_start = cfg_start;
      st_cnt = cfg_start ? st_cnt + 1 : 0;
      lock_ok = (st_cnt >= 3) && !(int'(cfg_wr_shift) == kill_lock_sh && lane(0) == kill_lock_dl);
      init_ok = (st_cnt >= 6) && !(int'(cfg_wr_shift) == kill_init_sh && lane(0) == kill_init_dl);
      if (init_ok && !prev_init) init_cyc = cyc;
      prev_init = init_ok;
      if (mem_we) begin
        if (!seen_we && cyc - init_cyc < SETTLE + 1) settle_err++;
        seen_we = 1;
        mem[mem_addr] = mem_wdata;
        if (mem_wdata != pat(int'(mem_addr))) wr_err++;
      end
      if (mem_re) begin
        mem_rdata = mem[mem_addr];
        if (mem_addr == 0) begin
          if (rd0 == 1 && !good_pt(int'(cfg_wr_shift), lane(0))) mem_rdata = ~mem_rdata;
          rd0++;
        end
        rd_pt++;
      end
    end
  end

  task automatic run_reset(input logic [47:0] m);
    rst = 1; cur_mask = m;
    pt_idx = 0; order_err = 0; wr_err = 0; rd_err = 0; settle_err = 0;
    repeat (3) @(negedge clk);
    chk(!cfg_start && !cal_done && !cal_error && !mem_we && !mem_re, "R3 reset state",
        int'({cfg_start, cal_done, cal_error, mem_we}), 0);
    rst = 0;
  endtask

  task automatic wait_end(output logic hung);
    int wd = 0;
    while (!(cal_done || cal_error) && wd < 60000) begin
      @(negedge clk); wd++;
    end
    hung = !(cal_done || cal_error);
    chk(!hung, "R9 watchdog", wd, 60000);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    logic hung;
    cyc = 0; init_cyc = 0; seen_we = 0; rd_pt = 0; rd0 = 0;
    for (int s = 0; s < 5; s++) begin
      int lane_bad;
      run_reset(SCEN[s].mask);
      wait_end(hung);
      chk(cal_done && !cal_error, "R9 done", int'({cal_done, cal_error}), 2);
      chk(no_window == SCEN[s].nowin, "R10 no_window", no_window, SCEN[s].nowin);
      chk(int'(cfg_wr_shift) == int'(SCEN[s].shift), "R9 best shift", cfg_wr_shift, SCEN[s].shift);
      chk(int'(cfg_out_shift) == int'(SCEN[s].shift) + 32, "R2 out shift",
          cfg_out_shift, int'(SCEN[s].shift) + 32);
      lane_bad = 0;
      for (int k = 0; k < LANES; k++) if (lane(k) != int'(SCEN[s].mid)) lane_bad++;
      chk(lane_bad == 0, "R9 midpoint on all lanes R2", lane(LANES-1), SCEN[s].mid);
      chk(win_lo == SCEN[s].lo && win_hi == SCEN[s].hi, "R8 window bounds",
          int'(win_lo) * 100 + int'(win_hi), int'(SCEN[s].lo) * 100 + int'(SCEN[s].hi));
      chk(win_len == SCEN[s].len, "R8 window length", win_len, SCEN[s].len);
      chk(pt_idx == NSH*NDL + 1, "R3 start pulses", pt_idx, NSH*NDL + 1);
      chk(order_err == 0, "R1 sweep order", order_err, 0);
      chk(wr_err == 0, "R6 pattern words", wr_err, 0);
      chk(rd_err == 0, "R7 read count and early stop", rd_err, 0);
      chk(settle_err == 0, "R5 settle gap", settle_err, 0);
    end

    // Lock never rises at shift 65, delay 1
    kill_lock_sh = 65; kill_lock_dl = 1;
    run_reset(SCEN[0].mask);
    wait_end(hung);
    chk(cal_error && !cal_done && cfg_start, "R4 lock timeout", int'({cal_error, cal_done, cfg_start}), 5);
    chk(int'(cfg_wr_shift) == 65 && lane(0) == 1 && lane(8) == 1, "R4 failing point held",
        int'(cfg_wr_shift) * 100 + lane(0), 6501);
    kill_lock_sh = -1; kill_lock_dl = -1;

    // Init never rises at shift 64, delay 3
    kill_init_sh = 64; kill_init_dl = 3;
    run_reset(SCEN[0].mask);
    wait_end(hung);
    chk(cal_error && !cal_done, "R4 init timeout", int'({cal_error, cal_done}), 2);
    chk(int'(cfg_wr_shift) == 64 && lane(0) == 3, "R4 init failing point",
        int'(cfg_wr_shift) * 100 + lane(0), 6403);
    repeat (40) @(negedge clk);
    chk(cal_error && int'(cfg_wr_shift) == 64, "R4 error sticky", cal_error, 1);
    kill_init_sh = -1; kill_init_dl = -1;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule